// File: doc/BRIEF.md
# Bundle Macro-Op Fusion Stage

This stage sits across one decoded bundle of up to eight micro-op slots, just ahead of register renaming. It looks at each pair of adjacent slots and folds four common two-instruction idioms into one operation. The first two idioms are an add-immediate (or a move or load-immediate) feeding a return, and a load-immediate feeding a conditional branch. The other two are an upper-immediate or PC-relative upper-immediate feeding an add-immediate, and an upper-immediate feeding a load or store base. Matching is passed from each slot to the next as a hint, and slot 0 always gets "no match". Fused first instructions are not removed. They stay in their slot marked as a no-op, so renaming and commit queue positions do not change.

A fused constant is built from a 20-bit upper part and a 12-bit signed lower part. Only the upper part goes through a decrementer, which borrows one when the lower part is negative. There is no full-width adder. Every output field is registered, so the rewritten bundle appears one clock after it is presented. Slot classes are given on a 3-bit input code: 0 other, 1 add-immediate, 2 upper-immediate, 3 PC-upper, 4 indirect jump, 5 conditional branch, 6 load, 7 store. The output class code is 4 bits wide. It repeats these codes and adds 8 (fused add+return), 9 (branch with first operand replaced by a constant) and 10 (branch with second operand replaced by a constant).

Top module: `macroFuse`

## Requirements
- R1: A slot is rewritten as a second instruction only when it and the slot directly before it are both valid in the same bundle. Slot 0 is never a second instruction, and a candidate first instruction in the last slot is never fused.
- R2: An add-immediate (class 1, rd not x0) followed by an indirect jump (class 4) with rd = x0 and offset 0 is fused only when the add's rd differs from the jump's rs1. A jump that writes a register is never fused.
- R3: A fused add+return slot becomes class 8. It takes the add's rd as its rd, puts the add's rs1 in its rs2 field and the add's immediate in outAltImm, keeps its own rs1, and raises outWrites.
- R4: A load-immediate (class 1 with rs1 = x0) followed by a branch (class 5) is fused in either operand order. If rs1 matches the constant's rd, the output is class 9 with rs1 cleared. Otherwise, if rs2 matches, the output is class 10 with rs2 cleared. The constant goes to outAltImm, the rd is taken over and outWrites is raised. A class-1 op whose source is not x0 does not fuse with a branch.
- R5: The first slot of a register-writing fusion (pair types of R2 to R8) stays valid in place with outNoOp = 1 and outWrites = 0. A no-op slot is always followed by a valid slot that is not itself a no-op.
- R6: The fused 32-bit constant equals the upper-immediate value plus the sign-extended 12-bit lower immediate. Its low 12 bits pass through unchanged, and its upper 20 bits are decremented by one exactly when bit 11 of the lower immediate is set.
- R7: An upper-immediate (class 2) followed by an add-immediate with rd = rs1 = the upper's rd becomes class 1 with rs1 = x0 and the fused constant as immediate.
- R8: A PC-upper (class 3) followed by the same add-immediate form becomes class 3 with the fused constant as immediate and the PC of the PC-upper slot.
- R9: An upper-immediate followed by a load (class 6) or store (class 7) whose rs1 is the upper's rd rewrites the memory op to rs1 = x0 with the fused constant as offset. The upper-immediate slot is left unchanged and is not a no-op.
- R10: A slot already rewritten as the second instruction of a pair is never also used as the first instruction of the following pair.
- R11: Slots outside any fused pair come out with unchanged valid, class, registers, immediate and PC one clock after they are presented, and reset clears every output valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 8 | Slot valid flags |
| inClass | input | 8x3 | Slot operation class |
| inRd | input | 8x5 | Destination register |
| inRs1 | input | 8x5 | First source register |
| inRs2 | input | 8x5 | Second source register |
| inImm | input | 8x32 | Decoded immediate |
| inPc | input | 8x32 | Slot PC |
| outValid | output | 8 | Rewritten slot valid |
| outClass | output | 8x4 | Rewritten operation class |
| outRd | output | 8x5 | Rewritten destination |
| outRs1 | output | 8x5 | Rewritten first source |
| outRs2 | output | 8x5 | Rewritten second source |
| outImm | output | 8x32 | Rewritten immediate |
| outAltImm | output | 8x32 | Second immediate carried by fused return or branch |
| outPc | output | 8x32 | Rewritten PC |
| outNoOp | output | 8 | Slot is a fused first op kept only as a placeholder |
| outWrites | output | 8 | Slot writes its destination register |

## Verification
The assertions take for granted that the decoder only produces constants the merge logic can handle. Upper-immediate and PC-upper slots carry values whose low 12 bits are zero, and add-immediate slots carry a sign-extended 12-bit value. Two input checks catch any stimulus that breaks this. The bench builds every upper value as a 20-bit field shifted left and every add immediate by sign-extending a 12-bit pattern. Filler slots use the "other" class, which never takes part in a match. Each pair type is swept across every slot position.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int CLS_W = 3;
  localparam int UOP_W = 4;

  localparam logic [CLS_W-1:0] OP_OTHER  = 3'd0;
  localparam logic [CLS_W-1:0] OP_ADDI   = 3'd1;
  localparam logic [CLS_W-1:0] OP_LUI    = 3'd2;
  localparam logic [CLS_W-1:0] OP_AUIPC  = 3'd3;
  localparam logic [CLS_W-1:0] OP_JALR   = 3'd4;
  localparam logic [CLS_W-1:0] OP_BRANCH = 3'd5;
  localparam logic [CLS_W-1:0] OP_LOAD   = 3'd6;
  localparam logic [CLS_W-1:0] OP_STORE  = 3'd7;

  localparam logic [UOP_W-1:0] UOP_RETADD = 4'd8;
  localparam logic [UOP_W-1:0] UOP_BRK1   = 4'd9;
  localparam logic [UOP_W-1:0] UOP_BRK2   = 4'd10;

  typedef struct packed {
    logic killFirst;
    logic retAdd;
    logic brConstA;
    logic brConstB;
    logic constAdd;
    logic pcAdd;
    logic memBase;
  } fuseStrb_t;

  function automatic logic classWrites(input logic [UOP_W-1:0] u);
    return (u == {1'b0, OP_ADDI}) || (u == {1'b0, OP_LUI}) ||
           (u == {1'b0, OP_AUIPC}) || (u == {1'b0, OP_LOAD}) ||
           (u == {1'b0, OP_JALR}) || (u == UOP_RETADD) ||
           (u == UOP_BRK1) || (u == UOP_BRK2);
  endfunction
endpackage

// File: rtl/fuseCtrl.sv
module fuseCtrl
  import fuse_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int REG_W = 5,
  parameter int XLEN  = 32,
  parameter int LO_W  = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [SLOTS-1:0]                 valid,
  input  logic [SLOTS-1:0][CLS_W-1:0]      cls,
  input  logic [SLOTS-1:0][REG_W-1:0]      rd,
  input  logic [SLOTS-1:0][REG_W-1:0]      rs1,
  input  logic [SLOTS-1:0][REG_W-1:0]      rs2,
  input  logic [SLOTS-1:0][XLEN-1:0]       imm,
  output fuseStrb_t [SLOTS-1:0]            strb
);
  logic [SLOTS-1:0] mRet, mBrA, mBrB, mCon, mPc, mMem, taken;

  always_comb begin
    mRet = '0; mBrA = '0; mBrB = '0; mCon = '0; mPc = '0; mMem = '0;
    for (int i = 1; i < SLOTS; i++) begin
      // hint passed from slot i-1 to slot i
      logic hintAdd, hintLi, hintUp, hintPcUp, here;
      hintAdd  = valid[i-1] && cls[i-1] == OP_ADDI && rd[i-1] != '0;
      hintLi   = hintAdd && rs1[i-1] == '0;
      hintUp   = valid[i-1] && cls[i-1] == OP_LUI && rd[i-1] != '0;
      hintPcUp = valid[i-1] && cls[i-1] == OP_AUIPC && rd[i-1] != '0;
      here     = valid[i];
      mRet[i] = hintAdd && here && cls[i] == OP_JALR && rd[i] == '0 &&
                imm[i] == '0 && rs1[i] != rd[i-1];
      mBrA[i] = hintLi && here && cls[i] == OP_BRANCH && rs1[i] == rd[i-1];
      mBrB[i] = hintLi && here && cls[i] == OP_BRANCH && rs1[i] != rd[i-1] &&
                rs2[i] == rd[i-1];
      mCon[i] = hintUp && here && cls[i] == OP_ADDI && rd[i] == rd[i-1] &&
                rs1[i] == rd[i-1];
      mPc[i]  = hintPcUp && here && cls[i] == OP_ADDI && rd[i] == rd[i-1] &&
                rs1[i] == rd[i-1];
      mMem[i] = hintUp && here && (cls[i] == OP_LOAD || cls[i] == OP_STORE) &&
                rs1[i] == rd[i-1];
    end
    // a slot that closes a pair cannot open the next one
    taken = '0;
    for (int i = 1; i < SLOTS; i++)
      taken[i] = (mRet[i] | mBrA[i] | mBrB[i] | mCon[i] | mPc[i] | mMem[i]) &&
                 !taken[i-1];
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      strb[i].retAdd    = taken[i] && mRet[i];
      strb[i].brConstA  = taken[i] && mBrA[i];
      strb[i].brConstB  = taken[i] && mBrB[i];
      strb[i].constAdd  = taken[i] && mCon[i];
      strb[i].pcAdd     = taken[i] && mPc[i];
      strb[i].memBase   = taken[i] && mMem[i];
      strb[i].killFirst = 1'b0;
      if (i < SLOTS - 1)
        strb[i].killFirst = taken[i+1] && !mMem[i+1];
    end
  end

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : gInChk
      // R6
      lui_align_chk: assert property (@(posedge clk) disable iff (!rstN)
        (valid[g] && (cls[g] == OP_LUI || cls[g] == OP_AUIPC)) |-> imm[g][LO_W-1:0] == '0);
      // R6
      addi_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        (valid[g] && cls[g] == OP_ADDI) |->
          (imm[g][XLEN-1:LO_W-1] == '0 || imm[g][XLEN-1:LO_W-1] == '1));
    end
  endgenerate
endmodule

// File: rtl/fuseData.sv
module fuseData
  import fuse_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int REG_W = 5,
  parameter int XLEN  = 32,
  parameter int LO_W  = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  fuseStrb_t [SLOTS-1:0]            strb,
  input  logic [SLOTS-1:0]                 valid,
  input  logic [SLOTS-1:0][CLS_W-1:0]      cls,
  input  logic [SLOTS-1:0][REG_W-1:0]      rd,
  input  logic [SLOTS-1:0][REG_W-1:0]      rs1,
  input  logic [SLOTS-1:0][REG_W-1:0]      rs2,
  input  logic [SLOTS-1:0][XLEN-1:0]       imm,
  input  logic [SLOTS-1:0][XLEN-1:0]       pc,
  output logic [SLOTS-1:0]                 outValid,
  output logic [SLOTS-1:0][UOP_W-1:0]      outClass,
  output logic [SLOTS-1:0][REG_W-1:0]      outRd,
  output logic [SLOTS-1:0][REG_W-1:0]      outRs1,
  output logic [SLOTS-1:0][REG_W-1:0]      outRs2,
  output logic [SLOTS-1:0][XLEN-1:0]       outImm,
  output logic [SLOTS-1:0][XLEN-1:0]       outAltImm,
  output logic [SLOTS-1:0][XLEN-1:0]       outPc,
  output logic [SLOTS-1:0]                 outNoOp,
  output logic [SLOTS-1:0]                 outWrites
);
  localparam int HI_W = XLEN - LO_W;

  logic [SLOTS-1:0][XLEN-1:0]  mergedImm;
  logic [SLOTS-1:0][UOP_W-1:0] nClass;
  logic [SLOTS-1:0][REG_W-1:0] nRd, nRs1, nRs2;
  logic [SLOTS-1:0][XLEN-1:0]  nImm, nAlt, nPc;
  logic [SLOTS-1:0]            nNoOp, nWrites;

  // hi/lo merge: pass low part, borrow one from the high part when low is negative
  always_comb begin
    mergedImm = '0;
    for (int i = 1; i < SLOTS; i++)
      mergedImm[i] = {imm[i-1][XLEN-1:LO_W] - HI_W'(imm[i][LO_W-1]),
                      imm[i][LO_W-1:0]};
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      int p;
      p = (i == 0) ? 0 : i - 1;
      nClass[i] = {1'b0, cls[i]};
      nRd[i]    = rd[i];
      nRs1[i]   = rs1[i];
      nRs2[i]   = rs2[i];
      nImm[i]   = imm[i];
      nAlt[i]   = '0;
      nPc[i]    = pc[i];
      nNoOp[i]  = strb[i].killFirst;
      if (strb[i].retAdd) begin
        nClass[i] = UOP_RETADD;
        nRd[i]    = rd[p];
        nRs2[i]   = rs1[p];
        nAlt[i]   = imm[p];
      end
      if (strb[i].brConstA || strb[i].brConstB) begin
        nClass[i] = strb[i].brConstA ? UOP_BRK1 : UOP_BRK2;
        nRd[i]    = rd[p];
        nAlt[i]   = imm[p];
        if (strb[i].brConstA) nRs1[i] = '0;
        else                  nRs2[i] = '0;
      end
      if (strb[i].constAdd || strb[i].memBase) begin
        nRs1[i] = '0;
        nImm[i] = mergedImm[i];
      end
      if (strb[i].pcAdd) begin
        nClass[i] = {1'b0, OP_AUIPC};
        nRs1[i]   = '0;
        nImm[i]   = mergedImm[i];
        nPc[i]    = pc[p];
      end
      nWrites[i] = !nNoOp[i] && nRd[i] != '0 && classWrites(nClass[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= '0;
      outClass  <= '0;
      outRd     <= '0;
      outRs1    <= '0;
      outRs2    <= '0;
      outImm    <= '0;
      outAltImm <= '0;
      outPc     <= '0;
      outNoOp   <= '0;
      outWrites <= '0;
    end else begin
      outValid  <= valid;
      outClass  <= nClass;
      outRd     <= nRd;
      outRs1    <= nRs1;
      outRs2    <= nRs2;
      outImm    <= nImm;
      outAltImm <= nAlt;
      outPc     <= nPc;
      outNoOp   <= nNoOp;
      outWrites <= nWrites;
    end
  end

  generate
    for (genvar g = 1; g < SLOTS; g++) begin : gMergeChk
      // R6
      merge_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strb[g].constAdd || strb[g].pcAdd || strb[g].memBase) |->
          mergedImm[g] == imm[g-1] + {{HI_W{imm[g][LO_W-1]}}, imm[g][LO_W-1:0]});
    end
    for (genvar g = 0; g < SLOTS - 1; g++) begin : gNoOpChk
      // R5
      lone_noop_chk: assert property (@(posedge clk) disable iff (!rstN)
        outNoOp[g] |-> (outValid[g] && outValid[g+1] && !outNoOp[g+1] && !outWrites[g]));
    end
    for (genvar g = 0; g < SLOTS; g++) begin : gRetChk
      // R2
      ret_base_chk: assert property (@(posedge clk) disable iff (!rstN)
        (outValid[g] && outClass[g] == UOP_RETADD) |-> outRd[g] != outRs1[g]);
    end
  endgenerate
  // R1
  last_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[SLOTS-1] |-> !outNoOp[SLOTS-1]);
endmodule

// File: rtl/macroFuse.sv
module macroFuse
  import fuse_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int REG_W = 5,
  parameter int XLEN  = 32,
  parameter int LO_W  = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [SLOTS-1:0]                 inValid,
  input  logic [SLOTS-1:0][CLS_W-1:0]      inClass,
  input  logic [SLOTS-1:0][REG_W-1:0]      inRd,
  input  logic [SLOTS-1:0][REG_W-1:0]      inRs1,
  input  logic [SLOTS-1:0][REG_W-1:0]      inRs2,
  input  logic [SLOTS-1:0][XLEN-1:0]       inImm,
  input  logic [SLOTS-1:0][XLEN-1:0]       inPc,
  output logic [SLOTS-1:0]                 outValid,
  output logic [SLOTS-1:0][UOP_W-1:0]      outClass,
  output logic [SLOTS-1:0][REG_W-1:0]      outRd,
  output logic [SLOTS-1:0][REG_W-1:0]      outRs1,
  output logic [SLOTS-1:0][REG_W-1:0]      outRs2,
  output logic [SLOTS-1:0][XLEN-1:0]       outImm,
  output logic [SLOTS-1:0][XLEN-1:0]       outAltImm,
  output logic [SLOTS-1:0][XLEN-1:0]       outPc,
  output logic [SLOTS-1:0]                 outNoOp,
  output logic [SLOTS-1:0]                 outWrites
);
  fuseStrb_t [SLOTS-1:0] strb;

  fuseCtrl #(.SLOTS(SLOTS), .REG_W(REG_W), .XLEN(XLEN), .LO_W(LO_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .valid(inValid), .cls(inClass), .rd(inRd),
    .rs1(inRs1), .rs2(inRs2), .imm(inImm), .strb(strb)
  );

  fuseData #(.SLOTS(SLOTS), .REG_W(REG_W), .XLEN(XLEN), .LO_W(LO_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .valid(inValid), .cls(inClass),
    .rd(inRd), .rs1(inRs1), .rs2(inRs2), .imm(inImm), .pc(inPc),
    .outValid(outValid), .outClass(outClass), .outRd(outRd), .outRs1(outRs1),
    .outRs2(outRs2), .outImm(outImm), .outAltImm(outAltImm), .outPc(outPc),
    .outNoOp(outNoOp), .outWrites(outWrites)
  );
endmodule

// File: tb/test_macroFuse.sv
`timescale 1ns/1ps
module test_macroFuse;
  logic clk = 1'b0;
  logic rstN;
  always #2.5 clk = ~clk;

  logic [7:0]       inValid;
  logic [7:0][2:0]  inClass;
  logic [7:0][4:0]  inRd, inRs1, inRs2;
  logic [7:0][31:0] inImm, inPc;
  logic [7:0]       outValid, outNoOp, outWrites;
  logic [7:0][3:0]  outClass;
  logic [7:0][4:0]  outRd, outRs1, outRs2;
  logic [7:0][31:0] outImm, outAltImm, outPc;

  int nChk = 0;
  int nBad = 0;

  macroFuse i_macroFuse (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass), .inRd(inRd),
    .inRs1(inRs1), .inRs2(inRs2), .inImm(inImm), .inPc(inPc),
    .outValid(outValid), .outClass(outClass), .outRd(outRd), .outRs1(outRs1),
    .outRs2(outRs2), .outImm(outImm), .outAltImm(outAltImm), .outPc(outPc),
    .outNoOp(outNoOp), .outWrites(outWrites)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 8; i++) begin
      inValid[i] = 1'b1;
      inClass[i] = 3'd0;
      inRd[i]    = 5'(i + 1);
      inRs1[i]   = 5'(i + 9);
      inRs2[i]   = 5'(i + 17);
      inImm[i]   = 32'(i * 17 + 5);
      inPc[i]    = 32'h1000 + 32'(4 * i);
    end
  endtask

  task automatic put(input int s, input logic [2:0] c, input logic [4:0] d,
                     input logic [4:0] a, input logic [4:0] b, input logic [31:0] im);
    inClass[s] = c; inRd[s] = d; inRs1[s] = a; inRs2[s] = b; inImm[s] = im;
  endtask

  task automatic apply();
    @(posedge clk);
    #1;
  endtask

  // R11: untouched slots pass through
  task automatic passOthers(input int a, input int b);
    for (int i = 0; i < 8; i++)
      if (i != a && i != b) begin
        chk("R11", "pass class", 32'(outClass[i]), 32'(inClass[i]));
        chk("R11", "pass imm", outImm[i], inImm[i]);
        chk("R11", "pass noop", 32'(outNoOp[i]), 32'(inValid[i] & 1'b0));
      end
  endtask

  function automatic logic [31:0] sx12(input logic [11:0] v);
    return {{20{v[11]}}, v};
  endfunction

  initial begin
    #(5.0 * 150000);
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    logic [11:0] loTab [5];
    logic [19:0] hiTab [5];
    loTab[0] = 12'h000; loTab[1] = 12'h7FF; loTab[2] = 12'h800;
    loTab[3] = 12'hFFF; loTab[4] = 12'h123;
    hiTab[0] = 20'h12345; hiTab[1] = 20'h00000; hiTab[2] = 20'hABCDE;
    hiTab[3] = 20'hFFFFF; hiTab[4] = 20'h00001;
    rstN = 1'b0;
    fill();
    @(posedge clk); #1;
    chk("R11", "reset valid", 32'(outValid), 32'h0);
    @(negedge clk); rstN = 1'b1;
    #1;

    // R2 R3 R5: add/move/li + return at every position
    for (int p = 0; p < 7; p++) begin
      logic [4:0]  src;
      logic [31:0] aim;
      fill();
      src = (p % 3 == 0) ? 5'd0 : 5'd2;
      aim = (p % 2 == 1) ? 32'd0 : sx12(12'hFF8);
      put(p, 3'd1, 5'd5, src, 5'd0, aim);
      put(p + 1, 3'd4, 5'd0, 5'd1, 5'd0, 32'd0);
      apply();
      chk("R5", "ret first noop", 32'(outNoOp[p]), 32'd1);
      chk("R5", "ret first valid", 32'(outValid[p]), 32'd1);
      chk("R5", "ret first writes", 32'(outWrites[p]), 32'd0);
      chk("R3", "ret class", 32'(outClass[p+1]), 32'd8);
      chk("R3", "ret rd", 32'(outRd[p+1]), 32'd5);
      chk("R3", "ret rs1", 32'(outRs1[p+1]), 32'd1);
      chk("R3", "ret rs2", 32'(outRs2[p+1]), 32'(src));
      chk("R3", "ret alt", outAltImm[p+1], aim);
      chk("R3", "ret writes", 32'(outWrites[p+1]), 32'd1);
      passOthers(p, p + 1);
    end

    // R2: add destination equals jump base
    fill();
    put(2, 3'd1, 5'd1, 5'd2, 5'd0, 32'd16);
    put(3, 3'd4, 5'd0, 5'd1, 5'd0, 32'd0);
    apply();
    chk("R2", "rd==base noop", 32'(outNoOp[2]), 32'd0);
    chk("R2", "rd==base class", 32'(outClass[3]), 32'd4);
    // R2: jump that writes a link register
    fill();
    put(4, 3'd1, 5'd5, 5'd2, 5'd0, 32'd16);
    put(5, 3'd4, 5'd1, 5'd6, 5'd0, 32'd0);
    apply();
    chk("R2", "call noop", 32'(outNoOp[4]), 32'd0);
    chk("R2", "call class", 32'(outClass[5]), 32'd4);

    // R4: li + branch, both operand orders, every position
    for (int p = 0; p < 7; p++) begin
      for (int ord = 0; ord < 2; ord++) begin
        fill();
        put(p, 3'd1, 5'd10, 5'd0, 5'd0, 32'(p + 3));
        if (ord == 0) put(p + 1, 3'd5, 5'd0, 5'd10, 5'd11, 32'h40);
        else          put(p + 1, 3'd5, 5'd0, 5'd11, 5'd10, 32'h40);
        apply();
        chk("R4", "br first noop", 32'(outNoOp[p]), 32'd1);
        chk("R4", "br class", 32'(outClass[p+1]), (ord == 0) ? 32'd9 : 32'd10);
        chk("R4", "br rs1", 32'(outRs1[p+1]), (ord == 0) ? 32'd0 : 32'd11);
        chk("R4", "br rs2", 32'(outRs2[p+1]), (ord == 0) ? 32'd11 : 32'd0);
        chk("R4", "br alt", outAltImm[p+1], 32'(p + 3));
        chk("R4", "br offset", outImm[p+1], 32'h40);
        chk("R4", "br rd", 32'(outRd[p+1]), 32'd10);
        chk("R4", "br writes", 32'(outWrites[p+1]), 32'd1);
        passOthers(p, p + 1);
      end
    end
    // R4: add with non-zero source does not fuse into a branch
    fill();
    put(1, 3'd1, 5'd10, 5'd3, 5'd0, 32'd5);
    put(2, 3'd5, 5'd0, 5'd10, 5'd11, 32'h40);
    apply();
    chk("R4", "addi src noop", 32'(outNoOp[1]), 32'd0);
    chk("R4", "addi src class", 32'(outClass[2]), 32'd5);

    // R6 R7 R8 R9: constant merge pairs over positions and constants
    for (int p = 0; p < 7; p++) begin
      for (int k = 0; k < 5; k++) begin
        logic [31:0] up, lo, want;
        up   = {hiTab[(k + p) % 5], 12'h000};
        lo   = sx12(loTab[k]);
        want = up + lo;
        // upper + add
        fill();
        put(p, 3'd2, 5'd6, 5'd0, 5'd0, up);
        put(p + 1, 3'd1, 5'd6, 5'd6, 5'd0, lo);
        apply();
        chk("R7", "lui+add noop", 32'(outNoOp[p]), 32'd1);
        chk("R7", "lui+add class", 32'(outClass[p+1]), 32'd1);
        chk("R7", "lui+add rs1", 32'(outRs1[p+1]), 32'd0);
        chk("R6", "lui+add const", outImm[p+1], want);
        passOthers(p, p + 1);
        // pc-upper + add
        fill();
        put(p, 3'd3, 5'd6, 5'd0, 5'd0, up);
        put(p + 1, 3'd1, 5'd6, 5'd6, 5'd0, lo);
        apply();
        chk("R8", "auipc noop", 32'(outNoOp[p]), 32'd1);
        chk("R8", "auipc class", 32'(outClass[p+1]), 32'd3);
        chk("R8", "auipc pc", outPc[p+1], 32'h1000 + 32'(4 * p));
        chk("R6", "auipc const", outImm[p+1], want);
        // upper + load / store
        for (int st = 0; st < 2; st++) begin
          fill();
          put(p, 3'd2, 5'd7, 5'd0, 5'd0, up);
          put(p + 1, (st == 0) ? 3'd6 : 3'd7, 5'd12, 5'd7, 5'd13, lo);
          apply();
          chk("R9", "mem upper noop", 32'(outNoOp[p]), 32'd0);
          chk("R9", "mem upper class", 32'(outClass[p]), 32'd2);
          chk("R9", "mem upper imm", outImm[p], up);
          chk("R9", "mem upper writes", 32'(outWrites[p]), 32'd1);
          chk("R9", "mem class", 32'(outClass[p+1]), (st == 0) ? 32'd6 : 32'd7);
          chk("R9", "mem base", 32'(outRs1[p+1]), 32'd0);
          chk("R9", "mem rs2", 32'(outRs2[p+1]), 32'd13);
          chk("R6", "mem const", outImm[p+1], want);
        end
      end
    end

    // R1: invalid second slot or invalid first slot blocks fusion
    fill();
    put(4, 3'd1, 5'd5, 5'd2, 5'd0, 32'd8);
    put(5, 3'd4, 5'd0, 5'd1, 5'd0, 32'd0);
    inValid[5] = 1'b0;
    apply();
    chk("R1", "inv second noop", 32'(outNoOp[4]), 32'd0);
    chk("R1", "inv second valid", 32'(outValid[5]), 32'd0);
    inValid[5] = 1'b1; inValid[4] = 1'b0;
    apply();
    chk("R1", "inv first class", 32'(outClass[5]), 32'd4);
    chk("R1", "inv first noop", 32'(outNoOp[4]), 32'd0);
    // R1: jump alone in slot 0, add alone in slot 7
    fill();
    put(0, 3'd4, 5'd0, 5'd1, 5'd0, 32'd0);
    put(7, 3'd1, 5'd5, 5'd2, 5'd0, 32'd8);
    apply();
    chk("R1", "slot0 class", 32'(outClass[0]), 32'd4);
    chk("R1", "slot7 noop", 32'(outNoOp[7]), 32'd0);
    chk("R1", "slot7 class", 32'(outClass[7]), 32'd1);

    // R10: upper/add/return chain - middle slot is consumed once
    fill();
    put(0, 3'd2, 5'd6, 5'd0, 5'd0, 32'h00042000);
    put(1, 3'd1, 5'd6, 5'd6, 5'd0, sx12(12'h010));
    put(2, 3'd4, 5'd0, 5'd1, 5'd0, 32'd0);
    apply();
    chk("R10", "chain first noop", 32'(outNoOp[0]), 32'd1);
    chk("R10", "chain mid noop", 32'(outNoOp[1]), 32'd0);
    chk("R10", "chain mid const", outImm[1], 32'h00042010);
    chk("R10", "chain ret class", 32'(outClass[2]), 32'd4);

    // R11: reset in the middle of traffic clears valids
    @(negedge clk); rstN = 1'b0;
    #1;
    chk("R11", "mid reset valid", 32'(outValid), 32'h0);
    rstN = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule